// File: doc/BRIEF.md
# Asynchronous Single-Bit Static RAM Sequencer

This block sits between a clocked host and an external asynchronous static RAM that stores one-bit words and has separate data-in and data-out pins. The host issues one access at a time with a one-cycle request that carries a write flag, a 20-bit address and a write bit. The sequencer then steps the memory pins through a fixed series of phases: setup, write pulse or read wait, and recovery. It signals completion with a one-cycle done pulse. Read results appear on a registered output bit.

Each phase length is a whole number of clock cycles, computed from nanosecond timing parameters and the clock-period parameter. Every value is rounded up, and no phase is shorter than one cycle. Writes are timed by write enable. Chip enable is held high whenever no access is in flight, so the memory stays in its automatic power-down state between accesses.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `ready`=1, `done`=0, `mem_ce_n`=1, `mem_we_n`=1 and `rd_data`=0.
- R2: `mem_ce_n` is 1 whenever `ready` is 1, so the memory is deselected (power-down) between accesses; it also rises when the recovery phase begins.
- R3: In a write, `mem_ce_n` is low for a setup phase before `mem_we_n` falls. `mem_we_n` is then low for PW = max over {T_PWE, T_AW, T_SCE, T_SD} of ceil(t/P) cycles. `mem_we_n` is never low while `mem_ce_n` is high.
- R4: `mem_addr` and `mem_din` do not change while `mem_ce_n` stays low, nor in the cycle after `mem_we_n` rises.
- R5: In a read, `mem_we_n` stays 1. `mem_dout` is registered into `rd_data` on the last of RA = ceil(T_AA/P)+1 read-wait cycles, and `rd_data` then holds until the next read completes.
- R6: `done` is high for exactly one cycle per access. Counted in cycles after the accepting edge, it comes in cycle SU+PW+RECW for a write and in cycle SU+RA+RECR for a read.
- R7: Each phase lasts ceil(t/P) cycles, with a minimum of 1. SU uses T_AS. RECW = max(1, ceil(T_RC/P)-SU-PW) and RECR = max(1, ceil(T_RC/P)-SU-RA). With the defaults (P=8 ns), writes finish in cycle 4 and reads in cycle 5.
- R8: A `req` seen while `ready` is 0 is dropped. It causes no extra `done` and no memory write, and it does not disturb the access in flight.
- R9: `ready` is 1 only when no access is in flight. It returns in the cycle after `done`, and a request in that cycle is accepted at once.
- R10: The memory pins meet the minimum write-pulse, data-setup and cycle times, with no address or data change during a write.
- R11: The full address range is reachable, including address 0 and all ones (20'hFFFFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | One-cycle access request, taken when `ready` is 1 |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 1 | Bit to write |
| rd_data | output | 1 | Last bit read |
| done | output | 1 | One-cycle completion pulse |
| ready | output | 1 | Idle and able to take a request |
| mem_addr | output | AW | Address pins of the RAM |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_din | output | 1 | Data-in pin of the RAM |
| mem_dout | input | 1 | Data-out pin of the RAM |

## Verification
The bench memory model returns the inverted bit until the address-to-data time has elapsed. A read wait that is one cycle too short therefore returns wrong data instead of passing by luck. The model also times every write-enable pulse, every data-setup interval and the spacing between chip-enable falls, and it flags any address move during a write. A sequencer with a short pulse, or one that releases the address early, therefore shows up as a nonzero violation count. A request injected mid-access targets a cleared address. A sequencer that latched it would either produce a second done pulse or leave a 1 at that address. Back-to-back accesses and both ends of the address range catch a lost cycle at the ready boundary and a truncated address.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_WPULSE = 3'd2,
    ST_RWAIT  = 3'd3,
    ST_RECOV  = 3'd4
  } seq_state_t;

  // nanoseconds to whole cycles, rounded up, never below one
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // recovery stretches the access up to the cycle time, at least one cycle
  function automatic int unsigned rec_cyc(int unsigned trc_cyc, int unsigned su,
                                          int unsigned mid);
    return (trc_cyc > su + mid + 1) ? (trc_cyc - su - mid) : 1;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val - CW'(1);
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  assign last = (cnt == '0);

  // a phase of length >= 1 never starts from a zero load
  assert_load_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    load |-> (load_val != '0));

endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int CW   = 4,
  parameter int SU   = 1,
  parameter int PW   = 2,
  parameter int RA   = 3,
  parameter int RECW = 1,
  parameter int RECR = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          is_wr,
  input  logic          last,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          ready,
  output logic          done,
  output logic          capture
);
  seq_state_t st, nxt;
  logic       rd_phase;

  always_comb begin
    nxt      = st;
    load     = 1'b0;
    load_val = '0;
    case (st)
      ST_IDLE: if (start) begin
        nxt = ST_SETUP; load = 1'b1; load_val = CW'(SU);
      end
      ST_SETUP: if (last) begin
        load = 1'b1;
        if (is_wr) begin nxt = ST_WPULSE; load_val = CW'(PW); end
        else       begin nxt = ST_RWAIT;  load_val = CW'(RA); end
      end
      ST_WPULSE: if (last) begin
        nxt = ST_RECOV; load = 1'b1; load_val = CW'(RECW);
      end
      ST_RWAIT: if (last) begin
        nxt = ST_RECOV; load = 1'b1; load_val = CW'(RECR);
      end
      ST_RECOV: if (last) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      mem_ce_n <= 1'b1;
      mem_we_n <= 1'b1;
    end else begin
      st       <= nxt;
      mem_ce_n <= !(nxt == ST_SETUP || nxt == ST_WPULSE || nxt == ST_RWAIT);
      mem_we_n <= !(nxt == ST_WPULSE);
    end
  end

  assign ready    = (st == ST_IDLE);
  assign done     = (st == ST_RECOV) && last;
  assign capture  = (st == ST_RWAIT) && last;
  assign rd_phase = (st == ST_RWAIT);

  assert_we_needs_ce_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_ce_n);
  assert_ce_before_we_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> $past(!mem_ce_n));
  assert_idle_deselected_R2: assert property (@(posedge clk) disable iff (rst)
    ready |-> mem_ce_n);
  assert_read_we_high_R5: assert property (@(posedge clk) disable iff (rst)
    rd_phase |-> mem_we_n);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_ready_after_done_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> ready);

endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int AW            = 20,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_RC_NS       = 12,
  parameter int T_AA_NS       = 12,
  parameter int T_PWE_NS      = 10,
  parameter int T_AW_NS       = 10,
  parameter int T_SCE_NS      = 10,
  parameter int T_SD_NS       = 7,
  parameter int T_AS_NS       = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic          req_wdata,
  output logic          rd_data,
  output logic          done,
  output logic          ready,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_din,
  input  logic          mem_dout
);
  localparam int unsigned P    = CLK_PERIOD_NS;
  localparam int unsigned SU   = ns_to_cyc(T_AS_NS, P);
  localparam int unsigned PW   = max2(max2(ns_to_cyc(T_PWE_NS, P), ns_to_cyc(T_AW_NS, P)),
                                      max2(ns_to_cyc(T_SCE_NS, P), ns_to_cyc(T_SD_NS, P)));
  localparam int unsigned RA   = ns_to_cyc(T_AA_NS, P) + 1;
  localparam int unsigned TRC  = ns_to_cyc(T_RC_NS, P);
  localparam int unsigned RECW = rec_cyc(TRC, SU, PW);
  localparam int unsigned RECR = rec_cyc(TRC, SU, RA);
  localparam int unsigned MAXL = max2(max2(SU, PW), max2(RA, max2(RECW, RECR)));
  localparam int          CW   = $clog2(MAXL + 1);

  logic          accept, wr_q, capture, load, last;
  logic [CW-1:0] load_val;
  logic [AW-1:0] addr_q;
  logic          din_q;

  assign accept = req && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      din_q   <= 1'b0;
      wr_q    <= 1'b0;
      rd_data <= 1'b0;
    end else begin
      if (accept) begin
        addr_q <= req_addr;
        din_q  <= req_wdata;
        wr_q   <= req_wr;
      end
      if (capture) rd_data <= mem_dout;
    end
  end

  assign mem_addr = addr_q;
  assign mem_din  = din_q;

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .last(last)
  );

  sram_seq_fsm #(
    .CW(CW), .SU(int'(SU)), .PW(int'(PW)), .RA(int'(RA)),
    .RECW(int'(RECW)), .RECR(int'(RECR))
  ) u_fsm (
    .clk(clk), .rst(rst), .start(accept), .is_wr(wr_q), .last(last),
    .load(load), .load_val(load_val), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .ready(ready), .done(done), .capture(capture)
  );

  assert_addr_hold_we_R4: assert property (@(posedge clk) disable iff (rst)
    $past(!mem_we_n) |-> ($stable(mem_addr) && $stable(mem_din)));
  assert_addr_hold_ce_R4: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
  assert_busy_req_dropped_R8: assert property (@(posedge clk) disable iff (rst)
    (req && !ready) |=> ($stable(mem_addr) && $stable(mem_din)));

endmodule

// File: tb/sram_seq_ctrl_test.sv
`timescale 1ns/1ps
module sram_bit_model #(
  parameter int AB   = 20,
  parameter int LB   = 10,
  parameter int TAA  = 12,
  parameter int TPWE = 10,
  parameter int TSD  = 7,
  parameter int TRC  = 12
) (
  input  logic [AB-1:0] addr,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          din,
  output logic          dout,
  output int            viol
);
  logic arr [0:(1<<LB)-1];
  time  t_chg, t_wf, t_din, t_cef;
  bit   have_cef, wr_open;

  initial begin
    for (int i = 0; i < (1<<LB); i++) arr[i] = 1'b0;
    viol = 0; t_chg = 0; t_wf = 0; t_din = 0; t_cef = 0;
    have_cef = 0; wr_open = 0; dout = 1'b0;
  end

  always @(addr or ce_n or we_n) t_chg = $time;
  always @(din) begin
    t_din = $time;
    if (wr_open) begin viol++; $display("MODEL: data moved during write"); end
  end
  always @(addr)
    if (wr_open) begin viol++; $display("MODEL: address moved during write"); end
  always @(negedge ce_n) begin
    if (have_cef && ($time - t_cef) < TRC) begin viol++; $display("MODEL: cycle too short"); end
    t_cef = $time; have_cef = 1;
  end
  always @(negedge we_n) if (!ce_n) begin t_wf = $time; wr_open = 1; end
  always @(posedge we_n) if (wr_open) begin
    if (($time - t_wf) < TPWE) begin viol++; $display("MODEL: write pulse too short"); end
    if (($time - t_din) < TSD) begin viol++; $display("MODEL: data setup too short"); end
    arr[addr[LB-1:0]] = din;
    wr_open = 0;
  end
  // access-time model: wrong (inverted) bit until TAA after the last change
  always begin
    #1;
    if (ce_n || !we_n)             dout = 1'b0;
    else if (($time - t_chg) >= TAA) dout = arr[addr[LB-1:0]];
    else                           dout = ~arr[addr[LB-1:0]];
  end
endmodule

module sram_seq_ctrl_test;
  localparam int AW = 20, P = 8, TRC = 12, TAA = 12, TPWE = 10, TAW = 10,
                 TSCE = 10, TSD = 7, TAS = 0;

  logic clk = 0, rst = 1, req = 0, req_wr = 0, req_wdata = 0;
  logic [AW-1:0] req_addr = '0;
  logic rd_data, done, ready, mem_ce_n, mem_we_n, mem_din, mem_dout;
  logic [AW-1:0] mem_addr;
  int viol;
  int errs = 0, checks = 0;
  bit ref_mem [0:1023];

  always #4 clk = ~clk;

  sram_seq_ctrl #(.AW(AW), .CLK_PERIOD_NS(P)) uut (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_data(rd_data), .done(done), .ready(ready),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_din(mem_din), .mem_dout(mem_dout)
  );

  sram_bit_model #(.AB(AW), .LB(10), .TAA(TAA), .TPWE(TPWE), .TSD(TSD), .TRC(TRC)) u_mem (
    .addr(mem_addr), .ce_n(mem_ce_n), .we_n(mem_we_n), .din(mem_din),
    .dout(mem_dout), .viol(viol)
  );

  // expected phase lengths, restated from the requirements
  function automatic int cyc(int ns);
    int c;
    c = ns / P + ((ns % P) != 0 ? 1 : 0);
    if (c < 1) c = 1;
    return c;
  endfunction
  function automatic int big(int a, int b); return a > b ? a : b; endfunction
  function automatic int exp_write_lat();
    int su, pw;
    su = cyc(TAS);
    pw = big(big(cyc(TPWE), cyc(TAW)), big(cyc(TSCE), cyc(TSD)));
    return su + pw + big(1, cyc(TRC) - su - pw);
  endfunction
  function automatic int exp_read_lat();
    int su, ra;
    su = cyc(TAS); ra = cyc(TAA) + 1;
    return su + ra + big(1, cyc(TRC) - su - ra);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // runs one access from a negedge; returns at the negedge after done
  task automatic access(bit wr, logic [AW-1:0] a, bit d, output bit rd, output int lat);
    while (!ready) @(negedge clk);
    req = 1; req_wr = wr; req_addr = a; req_wdata = d;
    @(negedge clk); req = 0; lat = 1;
    while (!done && lat < 60) begin @(negedge clk); lat++; end
    rd = rd_data;
    @(negedge clk);
    chk(!done, "R6 done longer than one cycle", int'(done), 0);
    chk(ready, "R9 ready not back after done", int'(ready), 1);
  endtask

  task automatic do_write(logic [AW-1:0] a, bit d);
    bit rd; int lat;
    access(1'b1, a, d, rd, lat);
    ref_mem[a[9:0]] = d;
    chk(lat == exp_write_lat(), "R6/R7 write latency", lat, exp_write_lat());
  endtask

  task automatic do_read(logic [AW-1:0] a, string tag);
    bit rd; int lat;
    access(1'b0, a, 1'b0, rd, lat);
    chk(lat == exp_read_lat(), "R6/R7 read latency", lat, exp_read_lat());
    chk(rd == ref_mem[a[9:0]], tag, int'(rd), int'(ref_mem[a[9:0]]));
  endtask

  task automatic test_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    chk(ready == 1 && done == 0, "R1 reset ready/done", {ready, done}, 2);
    chk(mem_ce_n == 1 && mem_we_n == 1, "R1 reset ce/we", {mem_ce_n, mem_we_n}, 3);
    rst = 0;
    @(negedge clk);
    chk(rd_data == 0 && ready == 1, "R1 after reset", {rd_data, ready}, 1);
    chk(mem_ce_n == 1, "R2 idle deselected", int'(mem_ce_n), 1);
  endtask

  task automatic test_pattern();
    for (int i = 0; i < 8; i++) do_write(AW'(16 + i), bit'(i % 3 == 0));
    for (int i = 7; i >= 0; i--) do_read(AW'(16 + i), "R5 read data pattern");
  endtask

  task automatic test_write_waveform();
    int low;
    while (!ready) @(negedge clk);
    req = 1; req_wr = 1; req_addr = 20'h00123; req_wdata = 1;
    @(negedge clk); req = 0;
    chk(mem_ce_n == 0 && mem_we_n == 1, "R3 setup phase CE low WE high",
        {mem_ce_n, mem_we_n}, 1);
    low = 0;
    @(negedge clk);
    while (!mem_we_n && low < 20) begin low++; @(negedge clk); end
    chk(low == big(big(cyc(TPWE), cyc(TAW)), big(cyc(TSCE), cyc(TSD))),
        "R3 write pulse cycles", low, 2);
    chk(mem_ce_n == 1 && mem_addr == 20'h00123, "R2/R4 recovery: CE high, address held",
        int'(mem_ce_n), 1);
    while (!ready) @(negedge clk);
    ref_mem[10'h123] = 1;
    do_read(20'h00123, "R3 written bit read back");
  endtask

  task automatic test_boundaries();
    do_write(20'h00000, 1);
    do_write(20'hFFFFF, 1);
    do_read(20'h00000, "R11 address zero");
    do_read(20'hFFFFF, "R11 address all ones");
    chk(mem_addr == 20'hFFFFF, "R11 full address on pins", int'(mem_addr), 20'hFFFFF);
    do_write(20'hFFFFF, 0);
    do_read(20'hFFFFF, "R11 all ones overwritten");
  endtask

  task automatic test_busy_ignore();
    int extra;
    while (!ready) @(negedge clk);
    req = 1; req_wr = 1; req_addr = 20'h00040; req_wdata = 1;
    @(negedge clk); req = 0;
    @(negedge clk);
    req = 1; req_wr = 1; req_addr = 20'h00041; req_wdata = 1;  // busy: must be dropped
    @(negedge clk); req = 0;
    chk(mem_addr == 20'h00040, "R8 address kept during busy request", int'(mem_addr), 'h40);
    while (!done) @(negedge clk);
    extra = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (done) extra++; end
    chk(extra == 0, "R8 no extra done from dropped request", extra, 0);
    ref_mem[10'h040] = 1;
    do_read(20'h00041, "R8 dropped write left memory unchanged");
    do_read(20'h00040, "R8 access in flight completed");
  endtask

  task automatic test_back_to_back();
    bit rd; int lat;
    access(1'b1, 20'h00200, 1, rd, lat);
    ref_mem[10'h200] = 1;
    chk(ready == 1, "R9 ready right after done", int'(ready), 1);
    access(1'b0, 20'h00200, 0, rd, lat);
    chk(rd == 1, "R9 back-to-back read", int'(rd), 1);
    chk(lat == exp_read_lat(), "R9 back-to-back read latency", lat, exp_read_lat());
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) ref_mem[i] = 0;
    test_reset();
    test_pattern();
    test_write_waveform();
    test_boundaries();
    test_busy_ignore();
    test_back_to_back();
    repeat (4) @(negedge clk);
    chk(viol == 0, "R10 memory timing violations", viol, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errs++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule